// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Arithmetic Unit

This block is a small register-mapped arithmetic engine. A host loads two 16-bit operands a byte at a time, picks an operation through a control byte, and starts the work by writing the upper byte of the second operand. Three operations are offered:

- a signed 16×16 product;
- division of a signed dividend by an unsigned divisor;
- a signed multiply-accumulate into a 40-bit running sum.

The result sits in a 40-bit register that the host reads back one byte at a time. A separate flag shows whether the last accumulation ran past the 40-bit range.

The datapath is fully combinational, so every operation finishes on the clock edge of the write that starts it. No busy indication is needed. Once an operation is done, the operands clear themselves. Which operands clear depends on the operation, so the host only needs to reload what the last operation consumed.

Top module: `mulDivAccUnit`

## Requirements
- R1: Write offset 0 is the control byte. Bit 1 set selects accumulate. Otherwise bit 0 selects divide (1) or multiply (0). A control write with bit 1 set clears the 40-bit result to zero and leaves the overflow flag unchanged.
- R2: Write offsets 1 and 2 load the low and high byte of operand A, and offset 3 loads the low byte of operand B. These writes change neither the result nor the overflow flag.
- R3: Writing offset 4 loads the high byte of B and starts the operation. In multiply mode the result becomes the signed product A×B, sign-extended to 40 bits. B is then cleared and A keeps its value. The overflow flag is unchanged.
- R4: In divide mode A is taken as signed and B as unsigned. The quotient, truncated toward zero, goes to result bits 15:0. The remainder, which carries the sign of the dividend, goes to bits 31:16. Bits 39:32 are zero.
- R5: A division by zero gives a result of zero. After any division both A and B are cleared.
- R6: In accumulate mode the signed product is added to the result and the sum is kept modulo 2^40. The overflow flag is overwritten with 1 when the exact sum (the result taken as unsigned plus the signed product) is at least 2^40 or below zero, and with 0 otherwise. B is then cleared and A keeps its value.
- R7: Read offsets 0 to 4 return result bytes 0 to 4, least significant byte first. Read offset 5 returns the overflow flag in bit 7, with bits 6:0 zero. Offsets 6 and 7 read as zero. Reads are combinational.
- R8: The result changes on the clock edge that takes the trigger write. A read made in that same cycle returns the previous result.
- R9: After reset the operands, the result and the overflow flag are zero, and the mode is multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write offset (0 control, 1..2 A, 3..4 B) |
| wrData | input | 8 | Write data byte |
| rdAddr | input | 3 | Read offset (0..4 result bytes, 5 overflow) |
| rdData | output | 8 | Combinational read data |

## Verification
The trigger write and a read of the result can fall in the same cycle, because the read port is combinational and independent of the write port. The bench drives a trigger write and points the read address at a result byte in the same low clock phase. The byte sampled before the edge must be the old result, and the byte sampled after the edge must be the new one. A control write that clears the result is also checked against a pending overflow flag, and the flag must survive the clear.

// File: rtl/mdaPkg.sv
package mdaPkg;
  localparam int ByteW   = 8;
  localparam int OpBytes = 2;
  localparam int OpW     = OpBytes * ByteW;
  localparam int AddrW   = 3;

  // write offsets (B high byte is the trigger)
  localparam logic [AddrW-1:0] WrCtrl = 3'd0;
  localparam logic [AddrW-1:0] WrALo  = 3'd1;
  localparam logic [AddrW-1:0] WrAHi  = 3'd2;
  localparam logic [AddrW-1:0] WrBLo  = 3'd3;
  localparam logic [AddrW-1:0] WrBHi  = 3'd4;

  typedef enum logic [1:0] {
    OpMul = 2'd0,
    OpDiv = 2'd1,
    OpAcc = 2'd2
  } opKind_e;

  typedef struct packed {
    logic loadALo;
    logic loadAHi;
    logic loadBLo;
    logic fire;
    logic clearRes;
  } strobes_t;
endpackage

// File: rtl/mdaCtrl.sv
module mdaCtrl
  import mdaPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [1:0]       ctrlBits,
  output strobes_t         strb,
  output opKind_e          opKind
);
  logic accMode;
  logic divMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accMode <= 1'b0;
      divMode <= 1'b0;
    end else if (wrEn && wrAddr == WrCtrl) begin
      accMode <= ctrlBits[1];
      divMode <= ctrlBits[0];
    end
  end

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (wrAddr)
        WrCtrl:  strb.clearRes = ctrlBits[1];
        WrALo:   strb.loadALo  = 1'b1;
        WrAHi:   strb.loadAHi  = 1'b1;
        WrBLo:   strb.loadBLo  = 1'b1;
        WrBHi:   strb.fire     = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  assign opKind = accMode ? OpAcc : (divMode ? OpDiv : OpMul);

  // R2: at most one register action per cycle
  assert_single_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R1: the mode only moves on a control write
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == WrCtrl) |=> $stable(opKind));
endmodule

// File: rtl/mdaDatapath.sv
module mdaDatapath
  import mdaPkg::*;
#(
  parameter int ResBytes = 5
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  opKind_e          opKind,
  input  logic [ByteW-1:0] wrData,
  input  logic [AddrW-1:0] rdAddr,
  output logic [ByteW-1:0] rdData
);
  localparam int ResW  = ResBytes * ByteW;
  localparam int ProdW = 2 * OpW;

  logic [OpW-1:0]  opA;
  logic [OpW-1:0]  opB;
  logic [ResW-1:0] result;
  logic            ovfFlag;

  // operand B as seen by the trigger write
  logic [OpW-1:0] bFull;
  assign bFull = {wrData, opB[ByteW-1:0]};

  // signed multiply
  logic signed [ProdW-1:0] prod;
  logic [ResW-1:0]         prodExt;
  assign prod    = $signed(opA) * $signed(bFull);
  assign prodExt = {{(ResW-ProdW){prod[ProdW-1]}}, prod};

  // signed-by-unsigned divide, truncating toward zero
  logic signed [OpW:0] dividend;
  logic signed [OpW:0] divisor;
  logic                divZero;
  logic [OpW-1:0]      quo;
  logic [OpW-1:0]      rem;
  logic [ResW-1:0]     divPacked;
  assign dividend  = {opA[OpW-1], opA};
  assign divZero   = (bFull == '0);
  assign divisor   = divZero ? (OpW+1)'(1) : {1'b0, bFull};
  assign quo       = OpW'(dividend / divisor);
  assign rem       = OpW'(dividend % divisor);
  assign divPacked = divZero ? '0 : {{(ResW-2*OpW){1'b0}}, rem, quo};

  // accumulate: carry out xor product sign marks leaving [0, 2^ResW)
  logic [ResW:0] accSum;
  logic          accOvf;
  assign accSum = {1'b0, result} + {1'b0, prodExt};
  assign accOvf = accSum[ResW] ^ prod[ProdW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA     <= '0;
      opB     <= '0;
      result  <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (strb.loadALo)  opA[ByteW-1:0]   <= wrData;
      if (strb.loadAHi)  opA[OpW-1:ByteW] <= wrData;
      if (strb.loadBLo)  opB[ByteW-1:0]   <= wrData;
      if (strb.clearRes) result <= '0;
      if (strb.fire) begin
        unique case (opKind)
          OpMul: begin
            result <= prodExt;
            opB    <= '0;
          end
          OpDiv: begin
            result <= divPacked;
            opA    <= '0;
            opB    <= '0;
          end
          default: begin
            result  <= accSum[ResW-1:0];
            ovfFlag <= accOvf;
            opB     <= '0;
          end
        endcase
      end
    end
  end

  // byte-wide read mux, least significant byte at offset 0
  always_comb begin
    rdData = '0;
    for (int k = 0; k < ResBytes; k++)
      if (rdAddr == AddrW'(k)) rdData = result[k*ByteW +: ByteW];
    if (rdAddr == AddrW'(ResBytes)) rdData = {ovfFlag, {(ByteW-1){1'b0}}};
  end

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearRes |=> (result == '0) && $stable(ovfFlag));

  assert_load_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadALo || strb.loadAHi || strb.loadBLo) |=> $stable(result) && $stable(ovfFlag));

  assert_mul_operands_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && opKind == OpMul) |=> (opB == '0) && (opA == $past(opA)) && $stable(ovfFlag));

  assert_div_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && opKind == OpDiv) |=> (opA == '0) && (opB == '0));

  assert_div_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && opKind == OpDiv && wrData == '0 && opB[ByteW-1:0] == '0) |=> (result == '0));

  assert_div_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && opKind == OpDiv) |=> (result[ResW-1:2*OpW] == '0));

  assert_acc_operands_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && opKind == OpAcc) |=> (opB == '0) && (opA == $past(opA)));
endmodule

// File: rtl/mulDivAccUnit.sv
module mulDivAccUnit
  import mdaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData
);
  strobes_t strb;
  opKind_e  opKind;

  mdaCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ctrlBits (wrData[1:0]),
    .strb     (strb),
    .opKind   (opKind)
  );

  mdaDatapath #(.ResBytes(5)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opKind (opKind),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: tb/test_mulDivAccUnit.sv
module test_mulDivAccUnit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mulDivAccUnit i_mulDivAccUnit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // bench model state
  logic [15:0] mA = '0, mB = '0;
  logic [39:0] mRes = '0;
  logic        mOvf = 1'b0, mAcc = 1'b0, mDiv = 1'b0;

  // vector: {writeCtrl, ctrl, A, B}
  localparam int NV = 14;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 16'd3,    16'd4},
    {1'b0, 8'h00, 16'hFFFE, 16'd5},
    {1'b0, 8'h00, 16'h8000, 16'h8000},
    {1'b0, 8'h00, 16'h7FFF, 16'hFFFF},
    {1'b1, 8'h01, 16'd100,  16'd7},
    {1'b0, 8'h01, 16'hFF9C, 16'd7},
    {1'b0, 8'h01, 16'd5,    16'd0},
    {1'b0, 8'h01, 16'h8000, 16'hFFFF},
    {1'b0, 8'h01, 16'h7FFF, 16'h8000},
    {1'b1, 8'h02, 16'd1000, 16'd1000},
    {1'b0, 8'h02, 16'hFFFF, 16'h7FFF},
    {1'b1, 8'h02, 16'hFFFF, 16'h0001},
    {1'b0, 8'h02, 16'd1,    16'd1},
    {1'b0, 8'h02, 16'd2,    16'd3}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic modelWrite(input logic [2:0] a, input logic [7:0] d);
    longint p, s;
    int qa, qb, q, r;
    case (a)
      3'd0: begin mAcc = d[1]; mDiv = d[0]; if (d[1]) mRes = '0; end
      3'd1: mA[7:0] = d;
      3'd2: mA[15:8] = d;
      3'd3: mB[7:0] = d;
      3'd4: begin
        mB[15:8] = d;
        p = longint'($signed(mA)) * longint'($signed(mB));
        if (mAcc) begin
          s = longint'(mRes) + p;
          mOvf = (s >= (64'sd1 <<< 40)) || (s < 0);
          mRes = s[39:0];
          mB = '0;
        end else if (mDiv) begin
          if (mB == 16'd0) mRes = '0;
          else begin
            qa = int'($signed(mA)); qb = int'(mB);
            q = qa / qb; r = qa % qb;
            mRes = {8'h00, r[15:0], q[15:0]};
          end
          mA = '0; mB = '0;
        end else begin
          mRes = p[39:0];
          mB = '0;
        end
      end
      default: ;
    endcase
  endtask

  task automatic wrM(input logic [2:0] a, input logic [7:0] d);
    wr(a, d);
    modelWrite(a, d);
  endtask

  task automatic readRes(output logic [39:0] v, output logic o);
    for (int k = 0; k < 5; k++) begin
      rdAddr = 3'(k); #1;
      v[k*8 +: 8] = rdData;
    end
    rdAddr = 3'd5; #1;
    o = rdData[7];
  endtask

  logic [39:0] res;
  logic        ovf;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    readRes(res, ovf);
    check("R9 reset result", 64'(res), 64'd0);
    check("R9 reset overflow", 64'(ovf), 64'd0);
    // R9: default mode multiply
    wrM(3'd1, 8'd6); wrM(3'd3, 8'd7); wrM(3'd4, 8'd0);
    readRes(res, ovf);
    check("R9 default multiply", 64'(res), 64'd42);

    // R2: operand writes leave the result alone
    wrM(3'd1, 8'd9); wrM(3'd3, 8'd9); wrM(3'd2, 8'd0);
    readRes(res, ovf);
    check("R2 result unchanged by operand writes", 64'(res), 64'd42);

    // R3: A kept, B cleared after multiply
    wrM(3'd4, 8'd0);
    readRes(res, ovf);
    check("R3 multiply 9*9", 64'(res), 64'd81);
    wrM(3'd4, 8'd1);
    readRes(res, ovf);
    check("R3 A kept, B low cleared", 64'(res), 64'd2304);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wrM(3'd0, VEC[i][39:32]);
      wrM(3'd1, VEC[i][23:16]); wrM(3'd2, VEC[i][31:24]);
      wrM(3'd3, VEC[i][7:0]);   wrM(3'd4, VEC[i][15:8]);
      readRes(res, ovf);
      if (mAcc) begin
        check($sformatf("R6 acc vector %0d result", i), 64'(res), 64'(mRes));
        check($sformatf("R6 acc vector %0d overflow", i), 64'(ovf), 64'(mOvf));
      end else if (mDiv)
        check($sformatf("R4 R5 div vector %0d", i), 64'(res), 64'(mRes));
      else
        check($sformatf("R3 mul vector %0d", i), 64'(res), 64'(mRes));
    end

    // R6 corner values computed by hand
    wrM(3'd0, 8'h02); wrM(3'd1, 8'hFF); wrM(3'd2, 8'hFF); wrM(3'd3, 8'h01); wrM(3'd4, 8'h00);
    readRes(res, ovf);
    check("R6 negative from zero wraps", 64'(res), 64'hFF_FFFF_FFFF);
    check("R6 negative from zero overflow", 64'(ovf), 64'd1);

    // R1: control clear keeps overflow
    wrM(3'd0, 8'h02);
    readRes(res, ovf);
    check("R1 clear result", 64'(res), 64'd0);
    check("R1 clear keeps overflow", 64'(ovf), 64'd1);
    // R3: multiply leaves overflow
    wrM(3'd0, 8'h00); wrM(3'd1, 8'd2); wrM(3'd2, 8'd0); wrM(3'd3, 8'd3); wrM(3'd4, 8'd0);
    readRes(res, ovf);
    check("R3 multiply 2*3", 64'(res), 64'd6);
    check("R3 multiply keeps overflow", 64'(ovf), 64'd1);

    // R5: operands cleared after divide
    wrM(3'd0, 8'h01); wrM(3'd1, 8'd100); wrM(3'd3, 8'd7); wrM(3'd4, 8'd0);
    readRes(res, ovf);
    check("R4 divide 100/7", 64'(res), 64'h00_0002_000E);
    wrM(3'd0, 8'h00); wrM(3'd4, 8'd1);
    readRes(res, ovf);
    check("R5 A cleared after divide", 64'(res), 64'd0);
    wrM(3'd1, 8'd3); wrM(3'd4, 8'd1);
    readRes(res, ovf);
    check("R5 B cleared after divide", 64'(res), 64'd768);

    // R8: trigger and read in the same cycle
    wrM(3'd1, 8'd5); wrM(3'd3, 8'd5);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd4; wrData = 8'd0; rdAddr = 3'd1; #1;
    check("R8 same-cycle read sees old byte", 64'(rdData), 64'd3);
    @(negedge clk);
    wrEn = 1'b0; #1;
    check("R8 new byte after edge", 64'(rdData), 64'd0);
    rdAddr = 3'd0; #1;
    check("R8 new low byte 5*5", 64'(rdData), 64'd25);

    // R7: read map edges
    rdAddr = 3'd5; #1;
    check("R7 overflow bits 6:0 zero", 64'(rdData & 8'h7F), 64'd0);
    rdAddr = 3'd6; #1;
    check("R7 offset 6 zero", 64'(rdData), 64'd0);
    rdAddr = 3'd7; #1;
    check("R7 offset 7 zero", 64'(rdData), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule